// File: doc/BRIEF.md
# Master-Mode Serial Audio Port

This block is the bus master of a serial link to a stereo audio codec. From a fast system clock it makes the bit clock with a divider whose ratio is a parameter. It also drives two identical frame clocks, one for the playback direction and one for the capture direction. Each frame is 64 bit clocks long, with a 32-bit-clock slot for each channel.

A 2-bit field selects one of four framings, and a 2-bit field selects the word length. Playback samples come from one port of an external dual-port RAM, which has a registered read with one cycle of latency. Captured samples go into the other port of the same RAM. An address counter for each direction wraps at a parameterised buffer depth. Two enable inputs gate playback and capture separately.

The block is used with the format and word-length fields held steady while reset is released. Software fills the playback area of the RAM and reads the capture area. Left samples sit at even addresses and right samples at the odd address that follows.

Top module: `sap_master_port`

## Requirements
- R1: The bit clock is low after reset and toggles once every CLK_DIV system clocks. A frame is 64 bit clocks long, and the first frame starts on the first falling bit-clock edge after reset.
- R2: The frame clocks and the DAC data change only in the system cycle in which the bit clock falls. ADC data is sampled when the bit clock rises, and RAM writes are issued in that same cycle.
- R3: The format field selects the framing with these codes: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP. The frame clock is high during the left slot in right-justified and left-justified modes. It is low during the left slot in I2S mode. In DSP mode it is high for only the first bit clock of the frame.
- R4: The word-length field selects the width with these codes: 00 16 bits, 01 20 bits, 10 24 bits, 11 32 bits. Words are sent MSB first, and every bit position outside a word is sent as 0.
- R5: In left-justified mode, the left MSB is on frame bit 0 and the right MSB is on frame bit 32.
- R6: In I2S mode, each MSB comes one bit clock after the frame-clock edge: on bit 1 for left and on bit 33 for right.
- R7: In right-justified mode, each word ends on the last bit of its slot. The left MSB is on bit 32−W and the right MSB is on bit 64−W.
- R8: In DSP mode the left MSB is on bit 1, and the right word follows the left LSB with no gap (right MSB on bit 1+W).
- R9: Right-justified framing with 32-bit words raises cfg_invalid. While that combination is selected, the DAC data stays 0 and the block makes no RAM reads and no RAM writes.
- R10: With playback enabled, each frame start fetches the next left/right pair from consecutive read addresses. The pair is sent in the following frame, and the first frame after reset sends zeros. The read address wraps from BUF_DEPTH−1 to 0. With playback disabled, the DAC data stays 0 and no reads are made.
- R11: With capture enabled, each received word is written zero-extended in the low W bits of the RAM word. The left word goes to an even address and the right word to the next address, wrapping at BUF_DEPTH. ADC bits outside a word are ignored. With capture disabled, no writes are made.
- R12: While reset is asserted, the bit clock, the frame clocks, the DAC data, the read enable and the write enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Framing select |
| cfg_wlen | input | 2 | Word-length select |
| play_en | input | 1 | Playback enable |
| cap_en | input | 1 | Capture enable |
| bclk | output | 1 | Bit clock to the codec |
| dac_lrclk | output | 1 | Playback frame clock |
| adc_lrclk | output | 1 | Capture frame clock |
| dac_dat | output | 1 | Serial data to the codec |
| adc_dat | input | 1 | Serial data from the codec |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | ADDR_W | RAM read address |
| rd_data | input | 32 | RAM read data, valid one cycle after rd_en |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | ADDR_W | RAM write address |
| wr_data | output | 32 | RAM write data |
| cfg_invalid | output | 1 | Unsupported format and word-length pair selected |

## Verification
The bench builds the block with CLK_DIV=2 and BUF_DEPTH=8. With these values a frame lasts 256 system cycles, so several frames of every framing fit in a short run. The shallow buffer makes both address counters wrap after only four frames, which brings the wrap of the read and write pointers into the checked window. The ADC input is looped back from the DAC output inside word positions and forced to 1 everywhere else. Each captured word must therefore match the sample sent, and every bit outside a word must be dropped.

// File: rtl/sap_pkg.sv
`timescale 1ns/1ps
package sap_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // Where a frame bit sits: inside a word or not, which channel, bit index from the MSB
  typedef struct packed {
    logic       valid;
    logic       chan;
    logic [4:0] k;
  } slot_t;

  function automatic logic [5:0] word_bits(input logic [1:0] wl);
    case (wl)
      2'b00:   return 6'd16;
      2'b01:   return 6'd20;
      2'b10:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic slot_t slot_map(input fmt_e fmt, input logic [5:0] w,
                                     input logic [5:0] pos);
    slot_t      s;
    logic [5:0] off;
    logic [5:0] d;
    logic [6:0] d7;
    logic [6:0] w7;
    case (fmt)
      FMT_LJ:  off = 6'd0;
      FMT_RJ:  off = 6'd32 - w;
      default: off = 6'd1;
    endcase
    d  = pos - off;
    d7 = {1'b0, d};
    w7 = {1'b0, w};
    s  = '0;
    if (fmt == FMT_DSP) begin
      if (d7 < w7) begin
        s = '{valid: 1'b1, chan: 1'b0, k: d[4:0]};
      end else if (d7 < (w7 << 1)) begin
        s = '{valid: 1'b1, chan: 1'b1, k: 5'(d7 - w7)};
      end
    end else begin
      s.chan  = d[5];
      s.k     = d[4:0];
      s.valid = ({1'b0, d[4:0]} < w);
    end
    return s;
  endfunction

  function automatic logic frame_level(input fmt_e fmt, input logic [5:0] pos);
    case (fmt)
      FMT_I2S: return pos[5];
      FMT_DSP: return (pos == 6'd0);
      default: return ~pos[5];
    endcase
  endfunction

endpackage

// File: rtl/sap_bclk_gen.sv
`timescale 1ns/1ps
module sap_bclk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(CLK_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bclk_q, bclk_d;
  logic          tick;

  always_comb begin
    tick   = (cnt_q == CW'(CLK_DIV - 1));
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    bclk_d = tick ? ~bclk_q : bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk      = bclk_q;
  assign rise_tick = tick & ~bclk_q;
  assign fall_tick = tick & bclk_q;
endmodule

// File: rtl/sap_framer.sv
`timescale 1ns/1ps
module sap_framer
  import sap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_tick,
  input  fmt_e       fmt,
  input  logic [5:0] wbits,
  output logic       lrclk,
  output logic       started,
  output slot_t      cur_map,
  output slot_t      nxt_map
);
  logic [5:0] pos_q, pos_d;
  logic       lr_q, lr_d;
  logic       run_q, run_d;

  always_comb begin
    pos_d = pos_q;
    lr_d  = lr_q;
    run_d = run_q;
    if (fall_tick) begin
      pos_d = pos_q + 6'd1;
      lr_d  = frame_level(fmt, pos_q + 6'd1);
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 6'd63;
      lr_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      lr_q  <= lr_d;
      run_q <= run_d;
    end
  end

  assign lrclk   = lr_q;
  assign started = run_q;
  assign cur_map = slot_map(fmt, wbits, pos_q);
  assign nxt_map = slot_map(fmt, wbits, pos_q + 6'd1);
endmodule

// File: rtl/sap_tx_path.sv
`timescale 1ns/1ps
module sap_tx_path
  import sap_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_tick,
  input  logic              tx_ok,
  input  logic [5:0]        wbits,
  input  slot_t             nxt_map,
  input  logic [31:0]       rd_data,
  output logic              dac_dat,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  typedef enum logic [1:0] {FT_IDLE, FT_LEFT, FT_RIGHT, FT_DONE} fetch_e;

  fetch_e            st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic [31:0]       pl_q, pl_d, pr_q, pr_d;
  logic [31:0]       al_q, al_d, ar_q, ar_d;
  logic [31:0]       src;
  logic [4:0]        idx;
  logic              dat_q, dat_d;
  logic              commit;

  always_comb begin
    commit  = fall_tick & nxt_map.valid & ~nxt_map.chan & (nxt_map.k == 5'd0);
    ptr_inc = (ptr_q == ADDR_W'(BUF_DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    st_d    = st_q;
    ptr_d   = ptr_q;
    pl_d    = pl_q;
    pr_d    = pr_q;
    rd_en   = 1'b0;
    case (st_q)
      FT_IDLE:  if (commit && tx_ok) st_d = FT_LEFT;
      FT_LEFT:  if (tx_ok) begin
                  rd_en = 1'b1;
                  ptr_d = ptr_inc;
                  st_d  = FT_RIGHT;
                end else st_d = FT_IDLE;
      FT_RIGHT: if (tx_ok) begin
                  rd_en = 1'b1;
                  ptr_d = ptr_inc;
                  pl_d  = rd_data;
                  st_d  = FT_DONE;
                end else st_d = FT_IDLE;
      default:  begin
                  pr_d = rd_data;
                  st_d = FT_IDLE;
                end
    endcase
    al_d = commit ? pl_q : al_q;
    ar_d = commit ? pr_q : ar_q;
    if (commit) src = nxt_map.chan ? pr_q : pl_q;
    else        src = nxt_map.chan ? ar_q : al_q;
    idx   = 5'(wbits - 6'd1 - {1'b0, nxt_map.k});
    dat_d = fall_tick ? (tx_ok & nxt_map.valid & src[idx]) : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FT_IDLE;
      ptr_q <= '0;
      pl_q  <= '0;
      pr_q  <= '0;
      al_q  <= '0;
      ar_q  <= '0;
      dat_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      pl_q  <= pl_d;
      pr_q  <= pr_d;
      al_q  <= al_d;
      ar_q  <= ar_d;
      dat_q <= dat_d;
    end
  end

  assign rd_addr = ptr_q;
  assign dac_dat = dat_q;
endmodule

// File: rtl/sap_rx_path.sv
`timescale 1ns/1ps
module sap_rx_path
  import sap_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_tick,
  input  logic              started,
  input  logic              rx_ok,
  input  logic [5:0]        wbits,
  input  slot_t             cur_map,
  input  logic              adc_dat,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);
  localparam int PAIR_W = ADDR_W - 1;
  localparam int PAIRS  = BUF_DEPTH / 2;

  logic [31:0]       sh_q, sh_d, mask;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [31:0]       wd_q, wd_d;
  logic              sample, last;

  always_comb begin
    mask   = (wbits == 6'd32) ? '1 : ((32'h1 << wbits) - 32'h1);
    sample = rise_tick & started & cur_map.valid;
    last   = sample & ({1'b0, cur_map.k} == (wbits - 6'd1));
    sh_d   = sample ? {sh_q[30:0], adc_dat} : sh_q;
    we_d   = last & rx_ok;
    wa_d   = wa_q;
    wd_d   = wd_q;
    pair_d = pair_q;
    if (last && rx_ok) begin
      wa_d = {pair_q, cur_map.chan};
      wd_d = {sh_q[30:0], adc_dat} & mask;
      if (cur_map.chan)
        pair_d = (pair_q == PAIR_W'(PAIRS - 1)) ? '0 : pair_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pair_q <= '0;
      we_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      pair_q <= pair_d;
      we_q   <= we_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
    end
  end

  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
endmodule

// File: rtl/sap_master_port.sv
`timescale 1ns/1ps
module sap_master_port
  import sap_pkg::*;
#(
  parameter  int CLK_DIV   = 4,
  parameter  int BUF_DEPTH = 256,
  localparam int ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_fmt,
  input  logic [1:0]        cfg_wlen,
  input  logic              play_en,
  input  logic              cap_en,
  output logic              bclk,
  output logic              dac_lrclk,
  output logic              adc_lrclk,
  output logic              dac_dat,
  input  logic              adc_dat,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              cfg_invalid
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  fmt_e       fmt;
  logic [5:0] wbits;
  logic       tx_ok, rx_ok;
  logic       rise_tick, fall_tick, started, lrclk;
  slot_t      cur_map, nxt_map;

  always_comb begin
    fmt         = fmt_e'(cfg_fmt);
    wbits       = word_bits(cfg_wlen);
    cfg_invalid = (fmt == FMT_RJ) && (cfg_wlen == 2'b11);
    tx_ok       = play_en & ~cfg_invalid;
    rx_ok       = cap_en & ~cfg_invalid;
  end

  sap_bclk_gen #(.CLK_DIV(CLK_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_sync_n), .bclk(bclk),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  sap_framer u_framer (
    .clk(clk), .rst_n(rst_sync_n), .fall_tick(fall_tick), .fmt(fmt),
    .wbits(wbits), .lrclk(lrclk), .started(started),
    .cur_map(cur_map), .nxt_map(nxt_map)
  );

  sap_tx_path #(.BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .fall_tick(fall_tick), .tx_ok(tx_ok),
    .wbits(wbits), .nxt_map(nxt_map), .rd_data(rd_data),
    .dac_dat(dac_dat), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  sap_rx_path #(.BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .rise_tick(rise_tick), .started(started),
    .rx_ok(rx_ok), .wbits(wbits), .cur_map(cur_map), .adc_dat(adc_dat),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign dac_lrclk = lrclk;
  assign adc_lrclk = lrclk;
endmodule

// File: rtl/sap_master_port_chk.sv
`timescale 1ns/1ps
module sap_master_port_chk #(
  parameter int CLK_DIV   = 4,
  parameter int BUF_DEPTH = 256,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bclk,
  input logic              dac_lrclk,
  input logic              adc_lrclk,
  input logic              dac_dat,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cfg_invalid,
  input logic              play_en,
  input logic              cap_en
);
  localparam int HW = $clog2(CLK_DIV + 2);

  logic          bclk_d;
  logic [HW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      held   <= '0;
    end else begin
      bclk_d <= bclk;
      if (bclk != bclk_d)              held <= HW'(1);
      else if (held != HW'(CLK_DIV+1)) held <= held + 1'b1;
    end
  end

  assert_bclk_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk != bclk_d) |-> (held == HW'(CLK_DIV)));

  assert_lrclk_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_lrclk) |-> $fell(bclk));

  assert_lrclk_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_lrclk == adc_lrclk);

  assert_dat_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_dat) |-> $fell(bclk));

  assert_write_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $rose(bclk));

  assert_invalid_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_invalid |-> (!rd_en && !wr_en));

  assert_play_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |-> !rd_en);

  assert_rd_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr <= ADDR_W'(BUF_DEPTH - 1)));

  assert_cap_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !wr_en);

  assert_wr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= ADDR_W'(BUF_DEPTH - 1)));
endmodule

bind sap_master_port sap_master_port_chk #(
  .CLK_DIV(CLK_DIV), .BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bclk(bclk), .dac_lrclk(dac_lrclk),
  .adc_lrclk(adc_lrclk), .dac_dat(dac_dat), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .cfg_invalid(cfg_invalid),
  .play_en(play_en), .cap_en(cap_en)
);

// File: tb/sim_sap_master_port.sv
`timescale 1ns/1ps
module sim_sap_master_port;
  localparam int DIV   = 2;
  localparam int DEPTH = 8;
  localparam int AW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_fmt = 2'b01, cfg_wlen = 2'b00;
  logic          play_en = 1'b0, cap_en = 1'b0;
  logic          bclk, dac_lrclk, adc_lrclk, dac_dat;
  logic          adc_dat = 1'b1;
  logic          rd_en, wr_en, cfg_invalid;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0]   rd_data = '0;
  logic [31:0]   wr_data;

  logic [31:0]   mem [DEPTH];
  logic [63:0]   frames [8];
  logic [AW-1:0] log_addr [64];
  logic [31:0]   log_data [64];
  int            nlog, nrd, nwr, nfr, q_now, frame_err;
  bit            synced;
  int            n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sap_master_port #(.CLK_DIV(DIV), .BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
    .play_en(play_en), .cap_en(cap_en), .bclk(bclk), .dac_lrclk(dac_lrclk),
    .adc_lrclk(adc_lrclk), .dac_dat(dac_dat), .adc_dat(adc_dat),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg_invalid(cfg_invalid)
  );

  // RAM model (registered read) and traffic monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      nrd = 0; nwr = 0; nlog = 0;
    end else begin
      if (rd_en) begin rd_data <= mem[rd_addr]; nrd++; end
      if (wr_en) begin
        nwr++;
        if (nlog < 64) begin log_addr[nlog] = wr_addr; log_data[nlog] = wr_data; nlog++; end
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  // Frame image with bit q of the result = value on frame bit q
  function automatic logic [63:0] exp_frame(input logic [1:0] fmt, input int w,
                                            input logic [31:0] l, input logic [31:0] r);
    int sl, sr;
    logic [63:0] f;
    f = '0;
    case (fmt)
      2'b01:   begin sl = 0;      sr = 32;     end
      2'b00:   begin sl = 32 - w; sr = 64 - w; end
      2'b10:   begin sl = 1;      sr = 33;     end
      default: begin sl = 1;      sr = 1 + w;  end
    endcase
    for (int i = 0; i < w; i++) begin
      f[(sl + i) % 64] = l[w - 1 - i];
      f[(sr + i) % 64] = r[w - 1 - i];
    end
    return f;
  endfunction

  task automatic do_reset(input logic [1:0] fmt, input logic [1:0] wl,
                          input logic pe, input logic ce);
    @(negedge clk);
    rst_n = 1'b0; cfg_fmt = fmt; cfg_wlen = wl; play_en = pe; cap_en = ce;
    adc_dat = 1'b1; synced = 0; q_now = 0; frame_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic collect(input int n, input logic [1:0] fmt);
    logic prev_lr;
    logic start;
    logic [63:0] cur;
    int q;
    prev_lr = dac_lrclk; q = 0; nfr = 0; cur = '0;
    while (nfr < n) begin
      @(posedge bclk); #1;
      if (fmt == 2'b11)      start = dac_lrclk;
      else if (fmt == 2'b10) start = prev_lr & ~dac_lrclk;
      else                   start = ~prev_lr & dac_lrclk;
      prev_lr = dac_lrclk;
      if (start) begin
        if (synced && q != 63) frame_err++;
        synced = 1; q = 0;
      end else if (synced) q = (q + 1) % 64;
      if (synced) begin
        cur[q] = dac_dat; q_now = q;
        if (q == 63) begin frames[nfr] = cur; nfr++; end
      end
    end
  endtask

  task automatic drive_adc(input logic [63:0] m, input bit loop);
    forever begin
      @(negedge bclk); #1;
      if (synced && loop && m[(q_now + 1) % 64]) adc_dat = dac_dat;
      else adc_dat = 1'b1;
    end
  endtask

  task automatic run_frames(input logic [63:0] m, input bit loop, input int n,
                            input logic [1:0] fmt);
    fork
      drive_adc(m, loop);
      collect(n, fmt);
    join_any
    disable fork;
  endtask

  task automatic t_reset_R12;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset outputs", {59'd0, bclk, dac_lrclk, dac_dat, rd_en, wr_en}, 64'd0);
  endtask

  task automatic t_bclk_R1;
    int last, bad, nr;
    logic prev;
    do_reset(2'b01, 2'b00, 1'b0, 1'b0);
    prev = bclk; last = -1; bad = 0; nr = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bclk && !prev) begin
        if (last >= 0 && (i - last) != 2 * DIV) bad++;
        last = i; nr++;
      end
      prev = bclk;
    end
    check("R1 bit clock period", bad, 0);
    check("R1 rises seen", nr, 200 / (2 * DIV));
  endtask

  // Full playback + loopback capture for one framing
  task automatic t_format(input logic [1:0] fmt, input logic [1:0] wl, input int w,
                          input string tag);
    int f0, i0, a0;
    do_reset(fmt, wl, 1'b1, 1'b1);
    check({tag, " R9 valid combination"}, cfg_invalid, 0);
    run_frames(exp_frame(fmt, w, 32'hFFFF_FFFF, 32'hFFFF_FFFF), 1, 8, fmt);
    check("R1 64-bit frames", frame_err, 0);
    f0 = -1;
    for (int f = 0; f < 3; f++)
      if (f0 < 0 && frames[f] == exp_frame(fmt, w, mem[0], mem[1])) f0 = f;
    check({tag, " R4 first pair placed"}, (f0 >= 0), 1);
    if (f0 < 0) f0 = 0;
    for (int k = 1; k <= 4; k++)
      check({tag, " R10 pair sequence and wrap"}, frames[f0 + k],
            exp_frame(fmt, w, mem[(2 * k) % DEPTH], mem[(2 * k + 1) % DEPTH]));
    i0 = -1;
    for (int i = 0; i < nlog; i++)
      if (i0 < 0 && log_data[i] == (mem[0] & wmask(w))) i0 = i;
    check({tag, " R11 capture found"}, (i0 >= 0 && i0 + 5 < nlog), 1);
    if (i0 >= 0 && i0 + 5 < nlog) begin
      a0 = log_addr[i0];
      check({tag, " R11 left on even address"}, a0 % 2, 0);
      for (int k = 1; k <= 5; k++) begin
        check({tag, " R11 capture data"}, log_data[i0 + k], mem[k % DEPTH] & wmask(w));
        check({tag, " R11 capture address"}, log_addr[i0 + k], (a0 + k) % DEPTH);
      end
    end
  endtask

  task automatic t_invalid_R9;
    do_reset(2'b00, 2'b11, 1'b1, 1'b1);
    run_frames('0, 0, 3, 2'b00);
    check("R9 flag raised", cfg_invalid, 1);
    check("R9 dac quiet", frames[0] | frames[1] | frames[2], 64'd0);
    check("R9 no reads", nrd, 0);
    check("R9 no writes", nwr, 0);
  endtask

  task automatic t_play_off_R10;
    do_reset(2'b01, 2'b00, 1'b0, 1'b1);
    run_frames('0, 0, 3, 2'b01);
    check("R10 play off dac quiet", frames[0] | frames[1] | frames[2], 64'd0);
    check("R10 play off no reads", nrd, 0);
    check("R11 capture active", (nwr > 0), 1);
    if (nlog > 0)
      check("R11 zero-extended, extra bits ignored", log_data[nlog - 1], 32'h0000_FFFF);
  endtask

  task automatic t_cap_off_R11;
    do_reset(2'b01, 2'b00, 1'b1, 1'b0);
    run_frames('0, 0, 3, 2'b01);
    check("R11 capture off no writes", nwr, 0);
    check("R10 reads made", (nrd > 0), 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0000;
    t_reset_R12();
    t_bclk_R1();
    t_format(2'b01, 2'b11, 32, "R5 LJ R3");
    t_format(2'b10, 2'b10, 24, "R6 I2S R3");
    t_format(2'b00, 2'b01, 20, "R7 RJ R3");
    t_format(2'b11, 2'b00, 16, "R8 DSP R3");
    t_invalid_R9();
    t_play_off_R10();
    t_cap_off_R11();
    t_reset_R12();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule